// File: doc/BRIEF.md
# USB Device Bulk Transaction Sequencer

This block sits between a USB packet layer and a peripheral's byte interface on the device side of a link. It turns decoded packet events (a packet identifier with a valid strobe, received data bytes, an end-of-packet mark and a CRC verdict) into complete bulk transactions.

For a host-to-device transfer, the sequencer waits for a data packet and forwards each payload byte to the peripheral. It then answers with a positive or a negative handshake. For a device-to-host transfer, it requests the transmitter and sends the data packet identifier. It then streams peripheral bytes until the peripheral runs dry, waits for the packet layer to confirm the end of the packet, and expects the host's positive handshake within a bounded number of cycles.

Any protocol violation, a peripheral that has nothing to send, or a missing handshake leads to a shared error state. That state raises a one-cycle alert.

The transmit side uses a valid/ready pair. A byte on `tx_data` is consumed on every clock where `tx_valid` and `tx_ready` are both high. Packet identifiers travel as 4-bit codes on the receive side. On the transmit side they travel as bytes whose upper nibble is the complement of the lower nibble.

Top module: `usb_xact_ctrl`

## Requirements
- R1: After reset, `busy`, `tx_valid`, `per_wr_valid`, `per_rd_take` and `xact_err` are all low.
- R2: From idle, `out_req` starts a receive transaction and `in_req` starts a transmit transaction; when both are high in the same cycle the receive transaction wins, and requests made while `busy` is high are ignored; `busy` is low again once a transaction has ended.
- R3: In a receive transaction, a packet identifier of 4'h3 or 4'hB is accepted as data; each following `rx_byte` is presented on `per_wr_data` with `per_wr_valid` in the same cycle; any other identifier while waiting for data raises the error alert instead.
- R4: When `rx_end` arrives with `crc_err` low and every byte accepted, the block transmits the single byte 8'hD2.
- R5: When `crc_err` is high with `rx_end`, or any byte arrived while `per_full` was high (that byte is not forwarded), the block transmits the single byte 8'h5A instead.
- R6: A handshake or data identifier byte is held on `tx_data` with `tx_valid` high until `tx_ready` is seen, and it is sent exactly once.
- R7: In a transmit transaction, the first byte sent is 8'h4B when `in_toggle` was high at the request and 8'hC3 otherwise; then peripheral bytes follow in order, each consumed with a `per_rd_take` pulse, until `per_rd_ready` goes low.
- R8: After `tx_fin`, a handshake identifier of 4'h2 ends the transaction with no alert; any other identifier raises the alert.
- R9: If no identifier arrives within `ACK_TIMEOUT` cycles after `tx_fin`, the alert is raised; an identifier arriving in the last of those cycles is still honoured.
- R10: If `per_rd_ready` is low when a transmit transaction starts, the alert is raised and no byte is transmitted.
- R11: The alert `xact_err` lasts exactly one cycle and the block is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| out_req | input | 1 | Start a host-to-device transaction |
| in_req | input | 1 | Start a device-to-host transaction |
| in_toggle | input | 1 | Selects the second data identifier for the transmit packet |
| pkt_valid | input | 1 | A decoded packet identifier is present |
| pkt_pid | input | 4 | Decoded packet identifier code |
| rx_byte_valid | input | 1 | A received payload byte is present |
| rx_byte | input | 8 | Received payload byte |
| rx_end | input | 1 | End of the received data packet |
| crc_err | input | 1 | CRC mismatch on the packet ending now |
| tx_ready | input | 1 | Transmitter accepts the byte on `tx_data` |
| tx_fin | input | 1 | Packet layer has finished the transmitted packet |
| per_full | input | 1 | Peripheral cannot take a byte this cycle |
| per_rd_ready | input | 1 | Peripheral has a byte to send |
| per_rd_data | input | 8 | Byte offered by the peripheral |
| busy | output | 1 | A transaction is in progress |
| tx_valid | output | 1 | `tx_data` holds a byte to transmit |
| tx_data | output | 8 | Byte to transmit |
| per_wr_valid | output | 1 | `per_wr_data` holds a byte for the peripheral |
| per_wr_data | output | 8 | Payload byte for the peripheral |
| per_rd_take | output | 1 | Peripheral byte consumed this cycle |
| xact_err | output | 1 | One-cycle error alert |

## Verification
Two functions can meet in the same cycle. The first is the arrival of the host's handshake and the expiry of the handshake wait, which the bench provokes by presenting the handshake exactly in the last allowed cycle and expecting no alert. The second is a receive request together with a transmit request, which the bench drives on the same clock. It judges the outcome by the bytes that appear: the receive path must forward the payload and answer 8'hD2, and no data identifier may be transmitted.

// File: rtl/usb_xact_pkg.sv
package usb_xact_pkg;
  localparam int BYTE_W = 8;
  localparam int PID_W  = 4;

  typedef logic [PID_W-1:0]  pid_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam pid_t PID_ACK   = 4'h2;
  localparam pid_t PID_NAK   = 4'hA;
  localparam pid_t PID_DATA0 = 4'h3;
  localparam pid_t PID_DATA1 = 4'hB;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OUT_START,
    ST_OUT_WAIT,
    ST_OUT_PID,
    ST_OUT_FIRST,
    ST_OUT_BODY,
    ST_SEND_ACK,
    ST_SEND_NAK,
    ST_IN_START,
    ST_IN_PID,
    ST_IN_DATA,
    ST_IN_FIN,
    ST_IN_HS,
    ST_ERR
  } xact_state_e;

  // Wire form of an identifier: check nibble above the code nibble.
  function automatic byte_t pid_byte(input pid_t p);
    return {~p, p};
  endfunction

  function automatic logic is_data_pid(input pid_t p);
    return (p == PID_DATA0) || (p == PID_DATA1);
  endfunction
endpackage

// File: rtl/usb_xact_rst_sync.sv
module usb_xact_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/usb_xact_hs_timer.sv
module usb_xact_hs_timer #(
  parameter int LIMIT = 16,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic          expired,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = run && (cnt_q == CW'(LIMIT - 1));
  assign cnt_en  = !run || !expired;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)          cnt_d = '0;
    else if (!expired) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/usb_xact_fsm.sv
module usb_xact_fsm
  import usb_xact_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        out_req,
  input  logic        in_req,
  input  logic        pkt_valid,
  input  pid_t        pkt_pid,
  input  logic        rx_byte_valid,
  input  logic        rx_end,
  input  logic        rx_reject,
  input  logic        tx_ready,
  input  logic        tx_fin,
  input  logic        per_rd_ready,
  input  logic        hs_expired,
  output xact_state_e state
);
  xact_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (out_req)     state_d = ST_OUT_START;
        else if (in_req) state_d = ST_IN_START;
      end
      ST_OUT_START: state_d = ST_OUT_WAIT;
      ST_OUT_WAIT: begin
        if (pkt_valid) state_d = is_data_pid(pkt_pid) ? ST_OUT_PID : ST_ERR;
      end
      ST_OUT_PID: state_d = ST_OUT_FIRST;
      ST_OUT_FIRST, ST_OUT_BODY: begin
        if (rx_end)             state_d = rx_reject ? ST_SEND_NAK : ST_SEND_ACK;
        else if (rx_byte_valid) state_d = ST_OUT_BODY;
      end
      ST_SEND_ACK, ST_SEND_NAK: begin
        if (tx_ready) state_d = ST_IDLE;
      end
      ST_IN_START: state_d = per_rd_ready ? ST_IN_PID : ST_ERR;
      ST_IN_PID: begin
        if (tx_ready) state_d = ST_IN_DATA;
      end
      ST_IN_DATA: begin
        if (!per_rd_ready) state_d = ST_IN_FIN;
      end
      ST_IN_FIN: begin
        if (tx_fin) state_d = ST_IN_HS;
      end
      ST_IN_HS: begin
        if (pkt_valid)       state_d = (pkt_pid == PID_ACK) ? ST_IDLE : ST_ERR;
        else if (hs_expired) state_d = ST_ERR;
      end
      ST_ERR:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/usb_xact_ctrl.sv
module usb_xact_ctrl
  import usb_xact_pkg::*;
#(
  parameter int ACK_TIMEOUT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       out_req,
  input  logic       in_req,
  input  logic       in_toggle,
  input  logic       pkt_valid,
  input  logic [3:0] pkt_pid,
  input  logic       rx_byte_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_end,
  input  logic       crc_err,
  input  logic       tx_ready,
  input  logic       tx_fin,
  input  logic       per_full,
  input  logic       per_rd_ready,
  input  logic [7:0] per_rd_data,
  output logic       busy,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       per_wr_valid,
  output logic [7:0] per_wr_data,
  output logic       per_rd_take,
  output logic       xact_err
);
  localparam int CW = $clog2(ACK_TIMEOUT + 1);

  logic          srst_n;
  xact_state_e   state;
  logic          hs_expired;
  logic [CW-1:0] hs_cnt;
  logic          collecting;
  logic          refused;
  logic          drop_q;
  logic          drop_en;
  logic          tog_q;
  logic          tog_en;
  logic          rx_reject;

  usb_xact_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  usb_xact_hs_timer #(.LIMIT(ACK_TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (srst_n),
    .run     (state == ST_IN_HS),
    .expired (hs_expired),
    .count   (hs_cnt)
  );

  usb_xact_fsm u_fsm (
    .clk           (clk),
    .rst_n         (srst_n),
    .out_req       (out_req),
    .in_req        (in_req),
    .pkt_valid     (pkt_valid),
    .pkt_pid       (pkt_pid),
    .rx_byte_valid (rx_byte_valid),
    .rx_end        (rx_end),
    .rx_reject     (rx_reject),
    .tx_ready      (tx_ready),
    .tx_fin        (tx_fin),
    .per_rd_ready  (per_rd_ready),
    .hs_expired    (hs_expired),
    .state         (state)
  );

  // Receive side: bytes refused by the peripheral poison the handshake.
  assign collecting = (state == ST_OUT_FIRST) || (state == ST_OUT_BODY);
  assign refused    = collecting && rx_byte_valid && per_full;
  assign rx_reject  = crc_err || drop_q || refused;
  assign drop_en    = (state == ST_OUT_START) || refused;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      drop_q <= 1'b0;
    else if (drop_en) drop_q <= (state != ST_OUT_START);
  end

  // Data identifier choice is captured with the transmit request.
  assign tog_en = (state == ST_IDLE) && !out_req && in_req;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     tog_q <= 1'b0;
    else if (tog_en) tog_q <= in_toggle;
  end

  assign per_wr_valid = collecting && rx_byte_valid && !per_full;
  assign per_wr_data  = rx_byte;

  always_comb begin
    tx_valid = 1'b0;
    tx_data  = '0;
    unique case (state)
      ST_SEND_ACK: begin tx_valid = 1'b1; tx_data = pid_byte(PID_ACK); end
      ST_SEND_NAK: begin tx_valid = 1'b1; tx_data = pid_byte(PID_NAK); end
      ST_IN_PID: begin
        tx_valid = 1'b1;
        tx_data  = pid_byte(tog_q ? PID_DATA1 : PID_DATA0);
      end
      ST_IN_DATA: begin tx_valid = per_rd_ready; tx_data = per_rd_data; end
      default: ;
    endcase
  end

  assign per_rd_take = (state == ST_IN_DATA) && per_rd_ready && tx_ready;
  assign busy        = (state != ST_IDLE);
  assign xact_err    = (state == ST_ERR);
endmodule

// File: rtl/usb_xact_ctrl_chk.sv
module usb_xact_ctrl_chk
  import usb_xact_pkg::*;
#(
  parameter int ACK_TIMEOUT = 16,
  parameter int CW          = 5
) (
  input logic          clk,
  input logic          srst_n,
  input xact_state_e   state,
  input logic [CW-1:0] hs_cnt,
  input logic          out_req,
  input logic          busy,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          per_wr_valid,
  input logic          rx_byte_valid,
  input logic          per_full,
  input logic          per_rd_take,
  input logic          per_rd_ready,
  input logic          xact_err
);
  assert_out_wins_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_IDLE && out_req) |=> (state == ST_OUT_START));

  assert_wr_gated_R3: assert property (@(posedge clk) disable iff (!srst_n)
    per_wr_valid |-> (rx_byte_valid && !per_full));

  assert_pid_held_R6: assert property (@(posedge clk) disable iff (!srst_n)
    ((state == ST_SEND_ACK || state == ST_SEND_NAK || state == ST_IN_PID) && !tx_ready)
      |=> (tx_valid && $stable(tx_data)));

  assert_take_sent_R7: assert property (@(posedge clk) disable iff (!srst_n)
    per_rd_take |-> (tx_valid && tx_ready && per_rd_ready));

  assert_wait_bound_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_IN_HS) |-> (int'(hs_cnt) < ACK_TIMEOUT));

  assert_busy_alert_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_IN_START && !per_rd_ready) |=> xact_err);

  assert_alert_pulse_R11: assert property (@(posedge clk) disable iff (!srst_n)
    xact_err |=> (!xact_err && !busy));
endmodule

bind usb_xact_ctrl usb_xact_ctrl_chk #(.ACK_TIMEOUT(ACK_TIMEOUT), .CW(CW)) u_chk (
  .clk           (clk),
  .srst_n        (srst_n),
  .state         (state),
  .hs_cnt        (hs_cnt),
  .out_req       (out_req),
  .busy          (busy),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .tx_data       (tx_data),
  .per_wr_valid  (per_wr_valid),
  .rx_byte_valid (rx_byte_valid),
  .per_full      (per_full),
  .per_rd_take   (per_rd_take),
  .per_rd_ready  (per_rd_ready),
  .xact_err      (xact_err)
);

// File: tb/usb_xact_ctrl_test.sv
module usb_xact_ctrl_test;
  localparam int LIMIT = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       out_req, in_req, in_toggle;
  logic       pkt_valid;
  logic [3:0] pkt_pid;
  logic       rx_byte_valid;
  logic [7:0] rx_byte;
  logic       rx_end, crc_err, tx_ready, tx_fin, per_full;
  logic       per_rd_ready;
  logic [7:0] per_rd_data;
  logic       busy, tx_valid, per_wr_valid, per_rd_take, xact_err;
  logic [7:0] tx_data, per_wr_data;

  int         nchecks = 0;
  int         nerr    = 0;
  int         err_seen = 0;
  int         err_mark = 0;
  bit         finished = 1'b0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_wr[$];

  // peripheral source model
  int         rd_total = 0;
  int         rd_idx   = 0;
  logic       rd_clr   = 1'b0;
  logic [7:0] rd_base  = 8'h00;

  always #5 clk = ~clk;

  usb_xact_ctrl #(.ACK_TIMEOUT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .out_req(out_req), .in_req(in_req),
    .in_toggle(in_toggle), .pkt_valid(pkt_valid), .pkt_pid(pkt_pid),
    .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rx_end(rx_end),
    .crc_err(crc_err), .tx_ready(tx_ready), .tx_fin(tx_fin),
    .per_full(per_full), .per_rd_ready(per_rd_ready), .per_rd_data(per_rd_data),
    .busy(busy), .tx_valid(tx_valid), .tx_data(tx_data),
    .per_wr_valid(per_wr_valid), .per_wr_data(per_wr_data),
    .per_rd_take(per_rd_take), .xact_err(xact_err)
  );

  assign per_rd_ready = (rd_idx < rd_total);
  assign per_rd_data  = rd_base + 8'(rd_idx);

  always @(posedge clk) begin
    if (rd_clr)           rd_idx <= 0;
    else if (per_rd_take) rd_idx <= rd_idx + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard: samples two time units before each rising edge
  always begin
    @(negedge clk);
    #3;
    if (tx_valid && tx_ready) begin
      if (exp_tx.size() == 0) chk(1'b0, "R6", "unexpected tx byte", tx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_tx.pop_front();
        chk(tx_data == e, "R6", "tx byte", tx_data, e);
      end
    end
    if (per_wr_valid) begin
      if (exp_wr.size() == 0) chk(1'b0, "R3", "unexpected write", per_wr_data, 0);
      else begin
        logic [7:0] e;
        e = exp_wr.pop_front();
        chk(per_wr_data == e, "R3", "peripheral byte", per_wr_data, e);
      end
    end
    if (xact_err) err_seen++;
  end

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic close_case(input string req, input int exp_err);
    repeat (4) cyc();
    chk(busy == 1'b0, "R2", {req, " idle after transaction"}, busy, 0);
    chk(exp_tx.size() == 0, req, "tx bytes left", exp_tx.size(), 0);
    chk(exp_wr.size() == 0, req, "writes left", exp_wr.size(), 0);
    chk(err_seen - err_mark == exp_err, req, "alert count", err_seen - err_mark, exp_err);
    err_mark = err_seen;
  endtask

  task automatic out_xact(input logic [3:0] pid, input int n, input bit crc_bad,
                          input int full_at, input logic [7:0] base, input bit both);
    exp_tx.push_back((crc_bad || full_at >= 0) ? 8'h5A : 8'hD2);
    cyc(); out_req = 1'b1; in_req = both;
    cyc(); out_req = 1'b0; in_req = 1'b0;
    cyc(); pkt_valid = 1'b1; pkt_pid = pid; in_req = both;
    cyc(); pkt_valid = 1'b0; in_req = 1'b0;
    for (int i = 0; i < n; i++) begin
      cyc();
      rx_byte_valid = 1'b1;
      rx_byte  = base + 8'(i);
      per_full = (i == full_at);
      if (i != full_at) exp_wr.push_back(base + 8'(i));
    end
    cyc(); rx_byte_valid = 1'b0; per_full = 1'b0; rx_end = 1'b1; crc_err = crc_bad;
    cyc(); rx_end = 1'b0; crc_err = 1'b0;
  endtask

  task automatic in_xact(input bit tog, input int n, input logic [7:0] base,
                         input bit send_hs, input logic [3:0] hs_pid, input int hs_delay);
    exp_tx.push_back(tog ? 8'h4B : 8'hC3);
    for (int i = 0; i < n; i++) exp_tx.push_back(base + 8'(i));
    cyc(); rd_clr = 1'b1;
    cyc(); rd_clr = 1'b0; rd_total = n; rd_base = base; in_toggle = tog; in_req = 1'b1;
    cyc(); in_req = 1'b0; in_toggle = 1'b0;
    do cyc(); while (rd_idx < rd_total);
    cyc(); tx_fin = 1'b1;
    cyc(); tx_fin = 1'b0;
    repeat (hs_delay) cyc();
    if (send_hs) begin
      pkt_valid = 1'b1; pkt_pid = hs_pid;
      cyc(); pkt_valid = 1'b0;
    end else begin
      repeat (LIMIT + 2) cyc();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nerr++; nchecks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {out_req, in_req, in_toggle, pkt_valid, rx_byte_valid, rx_end, crc_err} = '0;
    {tx_fin, per_full} = '0;
    tx_ready = 1'b1;
    pkt_pid = 4'h0; rx_byte = 8'h00;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(tx_valid == 1'b0, "R1", "tx_valid", tx_valid, 0);
    chk(per_wr_valid == 1'b0, "R1", "per_wr_valid", per_wr_valid, 0);
    chk(per_rd_take == 1'b0, "R1", "per_rd_take", per_rd_take, 0);
    chk(xact_err == 1'b0, "R1", "xact_err", xact_err, 0);

    // R3 R4 clean receive with DATA0
    out_xact(4'h3, 4, 1'b0, -1, 8'h10, 1'b0);
    close_case("R4", 0);

    // R5 R6 CRC error with DATA1, transmitter stalled
    tx_ready = 1'b0;
    out_xact(4'hB, 2, 1'b1, -1, 8'h40, 1'b0);
    for (int k = 0; k < 3; k++) begin
      chk(tx_valid == 1'b1, "R6", "valid held while stalled", tx_valid, 1);
      chk(tx_data == 8'h5A, "R6", "byte held while stalled", tx_data, 8'h5A);
      cyc();
    end
    tx_ready = 1'b1;
    close_case("R5", 0);

    // R5 refused byte not forwarded
    out_xact(4'h3, 3, 1'b0, 1, 8'h70, 1'b0);
    close_case("R5", 0);

    // R3 R11 non-data identifier while waiting for data
    cyc(); out_req = 1'b1;
    cyc(); out_req = 1'b0;
    cyc(); pkt_valid = 1'b1; pkt_pid = 4'h2;
    cyc(); pkt_valid = 1'b0;
    chk(xact_err == 1'b1, "R3", "alert on wrong identifier", xact_err, 1);
    cyc();
    chk(xact_err == 1'b0 && busy == 1'b0, "R11", "alert one cycle then idle",
        {xact_err, busy}, 0);
    close_case("R11", 1);

    // R7 R8 transmit with DATA1 and positive handshake
    in_xact(1'b1, 3, 8'hA0, 1'b1, 4'h2, 0);
    close_case("R8", 0);

    // R8 negative handshake raises the alert
    in_xact(1'b0, 2, 8'h20, 1'b1, 4'hA, 2);
    close_case("R8", 1);

    // R9 handshake in the last allowed cycle is honoured
    in_xact(1'b0, 1, 8'h55, 1'b1, 4'h2, LIMIT - 1);
    close_case("R9", 0);

    // R9 no handshake: timeout alert
    in_xact(1'b1, 1, 8'h66, 1'b0, 4'h0, 0);
    close_case("R9", 1);

    // R10 peripheral empty at transmit start
    cyc(); rd_clr = 1'b1;
    cyc(); rd_clr = 1'b0; rd_total = 0; in_req = 1'b1;
    cyc(); in_req = 1'b0;
    cyc();
    chk(xact_err == 1'b1, "R10", "alert when peripheral empty", xact_err, 1);
    close_case("R10", 1);

    // R2 both requests together and a request while busy: receive path only
    cyc(); rd_clr = 1'b1;
    cyc(); rd_clr = 1'b0; rd_total = 2;
    out_xact(4'h3, 2, 1'b0, -1, 8'h90, 1'b1);
    close_case("R2", 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule